// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

A bank of 32 general-purpose pins behind a small word-addressed register port. Software sets and clears output data and direction bits through dedicated alias registers, so several agents can change individual pins without a read-modify-write. For each pin, a pull-disable mask and an alternate-function mask complete the pin setup. When a pin is an input, its output data bit chooses whether the pull goes up or down.

Pad inputs are brought into the clock domain by a two-stage synchronizer and compared with their previous synchronized value. The resulting rising and falling edges are filtered by two per-pin enable masks. Each enabled edge sets a sticky status bit, which stays set until software writes a one to that bit in the clear register. One interrupt line is the OR of all status bits. A pin given to the alternate function gets no drive, no enable and no pull from this block, and its select bit is passed on to the peripheral side.

The register port accepts one access per cycle when `bus_sel` is high. `bus_ready` and `bus_rdata` answer on the following cycle.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all data, direction, pull-disable, alternate-function, mask and status bits are 0. As a result, pad_oe, pad_out, pad_pu, alt_sel and irq are 0, pad_pd is all ones, and bus_ready is 0.
- R2: A write to byte offset 0x04 sets the data bits where the written word has ones. A write to 0x08 clears them. Zero bits leave their pins unchanged. A direct write to offset 0x00 changes no data bit.
- R3: A write to 0x14 sets direction bits and a write to 0x18 clears them. Zero bits leave their pins unchanged. Offset 0x10 reads the direction register back. A direct write to 0x10 changes nothing.
- R4: A pin with direction 1 and alternate-function 0 has pad_oe 1, pad_out equal to its data bit, and both pulls 0.
- R5: A pin with direction 0 and alternate-function 0 has pad_oe 0. If its pull-disable bit (offset 0x0C, readable) is 0, data 1 gives pad_pu and data 0 gives pad_pd. If the pull-disable bit is 1, neither pull is on. Pull-up and pull-down are never on together.
- R6: A read of offset 0x00 returns the synchronized pad level. A pad change made before rising edge 1 is returned by a read accepted at edge 3 or later. A read accepted at edge 2 still returns the old level.
- R7: A pin whose alternate-function bit (offset 0x20, readable) is 1 has pad_oe, pad_out, pad_pu and pad_pd all 0, and its alt_sel output is 1.
- R8: A synchronized rising edge on a pin whose rising mask bit (0x40) is 1 sets that pin's status bit (0x48). So does a falling edge on a pin whose falling mask bit (0x44) is 1. With both mask bits set, both kinds of edge set the bit. An edge on an unmasked pin sets nothing.
- R9: Writing a word to 0x4C clears the status bits where the word has ones. Writing all ones clears every status bit.
- R10: If an enabled edge and a clear of the same status bit happen in the same cycle, the bit stays set. Other bits cleared in that write are still cleared.
- R11: irq is 1 exactly when at least one status bit is 1.
- R12: The following reads return 0: the alias offsets 0x04, 0x08, 0x14, 0x18 and 0x4C, any unmapped offset, any offset with address bits [1:0] not zero, and any write cycle.
- R13: bus_ready is 1 in the cycle after a cycle with bus_sel 1, and 0 in the cycle after a cycle with bus_sel 0. Read data is valid while bus_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed (one cycle after bus_sel) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| alt_sel | output | 32 | Pin handed to the alternate peripheral |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is an enabled edge that lands in the same cycle as a software clear of its own status bit. An edge becomes visible only after the synchronizer and the previous-value register, so the stimulus changes the pad and then waits exactly two rising edges before it issues the clear write. In that one write, it also clears a second status bit that has no new event, so a single access tests both the kept bit and the cleared bit. Read latency through the synchronizer is tested the same way: two reads are placed back to back, one on each side of the edge where the new level appears.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants of the GPIO bank.
// Register word indices (byte offset / 4) and a helper that tells whether
// a word index belongs to a readable/writable register.
package gpio_bank_pkg;

    localparam int ADDR_W = 8;
    localparam int WIDX_W = ADDR_W - 2;

    localparam logic [WIDX_W-1:0] W_DATA = 6'h00;
    localparam logic [WIDX_W-1:0] W_DSET = 6'h01;
    localparam logic [WIDX_W-1:0] W_DCLR = 6'h02;
    localparam logic [WIDX_W-1:0] W_PDIS = 6'h03;
    localparam logic [WIDX_W-1:0] W_DIR  = 6'h04;
    localparam logic [WIDX_W-1:0] W_DIRS = 6'h05;
    localparam logic [WIDX_W-1:0] W_DIRC = 6'h06;
    localparam logic [WIDX_W-1:0] W_ALT  = 6'h08;
    localparam logic [WIDX_W-1:0] W_RMSK = 6'h10;
    localparam logic [WIDX_W-1:0] W_FMSK = 6'h11;
    localparam logic [WIDX_W-1:0] W_STAT = 6'h12;
    localparam logic [WIDX_W-1:0] W_ICLR = 6'h13;

    // Returns 1 for word indices that return register contents on a read.
    function automatic logic word_readable(input logic [WIDX_W-1:0] w);
        case (w)
            W_DATA, W_PDIS, W_DIR, W_ALT, W_RMSK, W_FMSK, W_STAT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
// Module: gpio_sync_edge
// Brings asynchronous pad levels into the clock domain with two flops per
// pin, then compares with the value one cycle earlier to flag edges.
// Assumes pad_in meets no timing; only the second flop output is used.
module gpio_sync_edge #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        // Synchronizer chain plus one-cycle history of the synced level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pad_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Edge flags from current versus previous synchronized level.
        always_comb begin
            level[g] = sync_q;
            rise[g]  = sync_q & ~prev_q;
            fall[g]  = ~sync_q & prev_q;
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
// Module: gpio_irq_status
// Sticky per-pin interrupt status. Masked edges set bits, clear-mask bits
// reset them; a new event wins over a same-cycle clear. irq is the OR.
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise,
    input  logic [NPINS-1:0] fall,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status_q,
    output logic             irq
);

    logic [NPINS-1:0] events;

    // Edges that software has enabled.
    always_comb begin
        events = (rise & rise_en) | (fall & fall_en);
    end

    // Status update: clear first, then OR in new events so none is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | events;
        end
    end

    // Combined interrupt line.
    always_comb begin
        irq = |status_q;
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: gpio_pad_ctrl
// Per-pin pad drive. Alternate-function pins get nothing from the GPIO;
// outputs drive their data bit; inputs take a pull chosen by the data bit
// unless the pull is disabled. Purely combinational.
module gpio_pad_ctrl #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pdis_q,
    input  logic [NPINS-1:0] alt_q,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    output logic [NPINS-1:0] pad_pd
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // Select the pad controls of one pin from its configuration.
        always_comb begin
            pad_out[g] = 1'b0;
            pad_oe[g]  = 1'b0;
            pad_pu[g]  = 1'b0;
            pad_pd[g]  = 1'b0;
            if (!alt_q[g]) begin
                if (dir_q[g]) begin
                    pad_oe[g]  = 1'b1;
                    pad_out[g] = data_q[g];
                end else if (!pdis_q[g]) begin
                    pad_pu[g] = data_q[g];
                    pad_pd[g] = ~data_q[g];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_regfile.sv
// Module: gpio_regfile
// Register port: decodes word-aligned accesses, keeps data, direction,
// pull-disable, alternate-function and edge-mask registers, produces the
// interrupt clear mask and registered read data with a one-cycle ready.
// Assumes one access per cycle; misaligned addresses hit nothing.
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              bus_ready,
    input  logic [NPINS-1:0]  level,
    input  logic [NPINS-1:0]  status_q,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pdis_q,
    output logic [NPINS-1:0]  alt_q,
    output logic [NPINS-1:0]  rmask_q,
    output logic [NPINS-1:0]  fmask_q,
    output logic [NPINS-1:0]  clr_mask
);

    logic              aligned;
    logic [WIDX_W-1:0] widx;
    logic              wr_hit;
    logic              rd_hit;
    logic [NPINS-1:0]  rd_mux;

    // Address split and access qualification.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        widx    = bus_addr[ADDR_W-1:2];
        wr_hit  = bus_sel & bus_we & aligned;
        rd_hit  = bus_sel & ~bus_we & aligned;
    end

    // Configuration registers; data and direction only via aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            pdis_q  <= '0;
            alt_q   <= '0;
            rmask_q <= '0;
            fmask_q <= '0;
        end else if (wr_hit) begin
            case (widx)
                W_DSET:  data_q  <= data_q | bus_wdata;
                W_DCLR:  data_q  <= data_q & ~bus_wdata;
                W_DIRS:  dir_q   <= dir_q | bus_wdata;
                W_DIRC:  dir_q   <= dir_q & ~bus_wdata;
                W_PDIS:  pdis_q  <= bus_wdata;
                W_ALT:   alt_q   <= bus_wdata;
                W_RMSK:  rmask_q <= bus_wdata;
                W_FMSK:  fmask_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Write-one-to-clear mask for the status register.
    always_comb begin
        clr_mask = (wr_hit && widx == W_ICLR) ? bus_wdata : '0;
    end

    // Read multiplexer; aliases and holes read as zero.
    always_comb begin
        case (widx)
            W_DATA:  rd_mux = level;
            W_PDIS:  rd_mux = pdis_q;
            W_DIR:   rd_mux = dir_q;
            W_ALT:   rd_mux = alt_q;
            W_RMSK:  rd_mux = rmask_q;
            W_FMSK:  rd_mux = fmask_q;
            W_STAT:  rd_mux = status_q;
            default: rd_mux = '0;
        endcase
    end

    // Registered response: ready follows select by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            bus_rdata <= rd_hit ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
// Module: gpio_edge_bank (top)
// One GPIO bank: register port, pad control, input synchronizer with edge
// detection and sticky edge-interrupt status. Assumes a single clock and
// that alternate-function peripherals are muxed outside using alt_sel.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              bus_ready,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  alt_sel,
    output logic              irq
);

    logic [NPINS-1:0] level, rise, fall;
    logic [NPINS-1:0] data_q, dir_q, pdis_q, alt_q;
    logic [NPINS-1:0] rmask_q, fmask_q, clr_mask, status_q;

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .level     (level),
        .status_q  (status_q),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pdis_q    (pdis_q),
        .alt_q     (alt_q),
        .rmask_q   (rmask_q),
        .fmask_q   (fmask_q),
        .clr_mask  (clr_mask)
    );

    gpio_sync_edge #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .rise_en  (rmask_q),
        .fall_en  (fmask_q),
        .clr_mask (clr_mask),
        .status_q (status_q),
        .irq      (irq)
    );

    gpio_pad_ctrl #(.NPINS(NPINS)) u_pads (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pdis_q  (pdis_q),
        .alt_q   (alt_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu),
        .pad_pd  (pad_pd)
    );

    // Alternate-function selection handed to the peripheral mux.
    always_comb begin
        alt_sel = alt_q;
    end

endmodule

// File: rtl/gpio_edge_bank_chk.sv
// Module: gpio_edge_bank_chk
// Property checker bound into gpio_edge_bank. Observes the port, the
// status register, the edge flags and the mask registers.
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic              bus_ready,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pad_pd,
    input logic [NPINS-1:0]  alt_sel,
    input logic              irq,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  rise,
    input logic [NPINS-1:0]  fall,
    input logic [NPINS-1:0]  rmask,
    input logic [NPINS-1:0]  fmask
);

    logic [NPINS-1:0] ev;
    logic [NPINS-1:0] clr;
    logic             rd_zero;

    // Reconstructed events, clear request and zero-read condition.
    always_comb begin
        ev  = (rise & rmask) | (fall & fmask);
        clr = (bus_sel && bus_we && bus_addr == {W_ICLR, 2'b00}) ? bus_wdata : '0;
        rd_zero = bus_sel && !bus_we &&
                  (bus_addr[1:0] != 2'b00 || !word_readable(bus_addr[ADDR_W-1:2]));
    end

    p_ready_follow_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);
    p_ready_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ready);
    p_oe_nopull_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & (pad_pu | pad_pd)) == '0);
    p_pull_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);
    p_alt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_sel & (pad_oe | pad_out | pad_pu | pad_pd)) == '0);
    p_set_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(ev)) == '0);
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status & $past(clr & ~ev)) == '0);
    p_edge_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ev) & ~status) == '0);
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev) != '0);
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> bus_rdata == '0);

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .alt_sel   (alt_sel),
    .irq       (irq),
    .status    (status_q),
    .rise      (rise),
    .fall      (fall),
    .rmask     (rmask_q),
    .fmask     (fmask_q)
);

// File: tb/tb_gpio_edge_bank.sv
// Bench for gpio_edge_bank: directed stimulus, explicit checks, and a
// behavioural reference model compared with the outputs on every clock.
module tb_gpio_edge_bank;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    localparam logic [7:0] A_DATA = 8'h00, A_DSET = 8'h04, A_DCLR = 8'h08,
                           A_PDIS = 8'h0C, A_DIR = 8'h10, A_DIRS = 8'h14,
                           A_DIRC = 8'h18, A_ALT = 8'h20, A_RMSK = 8'h40,
                           A_FMSK = 8'h44, A_STAT = 8'h48, A_ICLR = 8'h4C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0, bus_rdata;
    logic         bus_ready;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd, alt_sel;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit seen_edge = 1'b0;

    gpio_edge_bank #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .alt_sel(alt_sel), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [N-1:0] m_data, m_dir, m_pdis, m_alt, m_rm, m_fm, m_stat;
    logic [N-1:0] m_s1, m_s2, m_prev, m_rdata;
    logic         m_ready;

    function automatic logic [N-1:0] m_read(input logic [7:0] a);
        case (a)
            A_DATA: return m_s2;
            A_PDIS: return m_pdis;
            A_DIR:  return m_dir;
            A_ALT:  return m_alt;
            A_RMSK: return m_rm;
            A_FMSK: return m_fm;
            A_STAT: return m_stat;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] ev, clr;
        seen_edge <= 1'b1;
        if (!rst_n) begin
            m_data = '0; m_dir = '0; m_pdis = '0; m_alt = '0;
            m_rm = '0; m_fm = '0; m_stat = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_rdata = '0; m_ready = 1'b0;
        end else begin
            ev = '0;
            for (int i = 0; i < N; i++) begin
                if (m_s2[i] && !m_prev[i] && m_rm[i]) ev[i] = 1'b1;
                if (!m_s2[i] && m_prev[i] && m_fm[i]) ev[i] = 1'b1;
            end
            clr = (bus_sel && bus_we && bus_addr == A_ICLR) ? bus_wdata : '0;
            m_ready = bus_sel;
            m_rdata = (bus_sel && !bus_we) ? m_read(bus_addr) : '0;
            m_stat = (m_stat & ~clr) | ev;
            if (bus_sel && bus_we) begin
                case (bus_addr)
                    A_DSET: m_data = m_data | bus_wdata;
                    A_DCLR: m_data = m_data & ~bus_wdata;
                    A_DIRS: m_dir  = m_dir | bus_wdata;
                    A_DIRC: m_dir  = m_dir & ~bus_wdata;
                    A_PDIS: m_pdis = bus_wdata;
                    A_ALT:  m_alt  = bus_wdata;
                    A_RMSK: m_rm   = bus_wdata;
                    A_FMSK: m_fm   = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        logic [N-1:0] e_out, e_oe, e_pu, e_pd;
        if (seen_edge && !done) begin
            e_out = '0; e_oe = '0; e_pu = '0; e_pd = '0;
            for (int i = 0; i < N; i++) begin
                if (!m_alt[i]) begin
                    if (m_dir[i]) begin
                        e_oe[i] = 1'b1;
                        e_out[i] = m_data[i];
                    end else if (!m_pdis[i]) begin
                        if (m_data[i]) e_pu[i] = 1'b1;
                        else e_pd[i] = 1'b1;
                    end
                end
            end
            check(pad_oe == e_oe, "R4 model pad_oe", pad_oe, e_oe);
            check(pad_out == e_out, "R4 model pad_out", pad_out, e_out);
            check(pad_pu == e_pu, "R5 model pad_pu", pad_pu, e_pu);
            check(pad_pd == e_pd, "R5 model pad_pd", pad_pd, e_pd);
            check(alt_sel == m_alt, "R7 model alt_sel", alt_sel, m_alt);
            check(irq == (m_stat != '0), "R11 model irq", N'(irq), N'(m_stat != '0));
            check(bus_ready == m_ready, "R13 model ready", N'(bus_ready), N'(m_ready));
            if (bus_ready)
                check(bus_rdata == m_rdata, "R12 model rdata", bus_rdata, m_rdata);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
        d = bus_rdata;
        check(bus_ready == 1'b1, "R13 ready after read", N'(bus_ready), N'(1));
    endtask

    task automatic set_pads(input logic [N-1:0] v);
        @(negedge clk); #1;
        pad_in = v;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [N-1:0] rd;
        wait_clk(3);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #2;

        // R1: reset state
        check(pad_oe == '0, "R1 pad_oe", pad_oe, '0);
        check(pad_out == '0, "R1 pad_out", pad_out, '0);
        check(pad_pu == '0, "R1 pad_pu", pad_pu, '0);
        check(pad_pd == '1, "R1 pad_pd", pad_pd, '1);
        check(alt_sel == '0, "R1 alt_sel", alt_sel, '0);
        check(irq == 1'b0, "R1 irq", N'(irq), '0);
        check(bus_ready == 1'b0, "R1 ready", N'(bus_ready), '0);
        bus_read(A_STAT, rd);
        check(rd == '0, "R1 status", rd, '0);

        // R2, R3, R4: aliases and output drive
        bus_write(A_DIRS, 32'h0000_00FF);
        check(pad_oe == 32'h0000_00FF, "R3 dir set", pad_oe, 32'h0000_00FF);
        bus_write(A_DSET, 32'h0000_00A5);
        check(pad_out == 32'h0000_00A5, "R2 data set", pad_out, 32'h0000_00A5);
        bus_write(A_DCLR, 32'h0000_000F);
        check(pad_out == 32'h0000_00A0, "R2 data clear", pad_out, 32'h0000_00A0);
        bus_write(A_DIRC, 32'h0000_000F);
        check(pad_oe == 32'h0000_00F0, "R3 dir clear", pad_oe, 32'h0000_00F0);
        check(pad_out == 32'h0000_00A0, "R4 out follows data", pad_out, 32'h0000_00A0);
        bus_write(A_DIR, 32'hFFFF_FFFF);
        bus_read(A_DIR, rd);
        check(rd == 32'h0000_00F0, "R3 direct dir write ignored", rd, 32'h0000_00F0);
        bus_write(A_DATA, 32'hFFFF_FFFF);
        check(pad_out == 32'h0000_00A0, "R2 direct data write ignored", pad_out, 32'h0000_00A0);

        // R5: pulls on input pins
        bus_write(A_DSET, 32'h0000_0F00);
        bus_write(A_PDIS, 32'h0000_0C00);
        check(pad_pu == 32'h0000_0300, "R5 pull-up", pad_pu, 32'h0000_0300);
        check(pad_pd == 32'hFFFF_F00F, "R5 pull-down", pad_pd, 32'hFFFF_F00F);
        bus_read(A_PDIS, rd);
        check(rd == 32'h0000_0C00, "R5 pdis readback", rd, 32'h0000_0C00);

        // R7: alternate function
        bus_write(A_ALT, 32'h0000_0130);
        check(pad_oe == 32'h0000_00C0, "R7 alt oe", pad_oe, 32'h0000_00C0);
        check(pad_out == 32'h0000_0080, "R7 alt out", pad_out, 32'h0000_0080);
        check(pad_pu == 32'h0000_0200, "R7 alt pu", pad_pu, 32'h0000_0200);
        check(alt_sel == 32'h0000_0130, "R7 alt_sel", alt_sel, 32'h0000_0130);
        bus_read(A_ALT, rd);
        check(rd == 32'h0000_0130, "R7 alt readback", rd, 32'h0000_0130);
        bus_write(A_ALT, 32'h0);
        check(pad_oe == 32'h0000_00F0, "R7 alt released", pad_oe, 32'h0000_00F0);

        // R6: synchronized data read and its latency
        set_pads(32'hDEAD_BEEF);
        wait_clk(3);
        bus_read(A_DATA, rd);
        check(rd == 32'hDEAD_BEEF, "R6 level read", rd, 32'hDEAD_BEEF);
        set_pads(32'h1234_5678);
        bus_read(A_DATA, rd);
        check(rd == 32'hDEAD_BEEF, "R6 read at edge 2 old", rd, 32'hDEAD_BEEF);
        bus_read(A_DATA, rd);
        check(rd == 32'h1234_5678, "R6 read at edge 3 new", rd, 32'h1234_5678);
        set_pads(32'h0);
        wait_clk(4);

        // R12: zero reads
        bus_read(A_DSET, rd);  check(rd == '0, "R12 read 0x04", rd, '0);
        bus_read(A_DCLR, rd);  check(rd == '0, "R12 read 0x08", rd, '0);
        bus_read(A_DIRS, rd);  check(rd == '0, "R12 read 0x14", rd, '0);
        bus_read(A_DIRC, rd);  check(rd == '0, "R12 read 0x18", rd, '0);
        bus_read(A_ICLR, rd);  check(rd == '0, "R12 read 0x4C", rd, '0);
        bus_read(8'h1C, rd);   check(rd == '0, "R12 read 0x1C", rd, '0);
        bus_read(8'hFC, rd);   check(rd == '0, "R12 read 0xFC", rd, '0);
        bus_read(8'h11, rd);   check(rd == '0, "R12 misaligned", rd, '0);

        // R8, R11: edge capture
        bus_write(A_RMSK, 32'h0000_0005);
        bus_write(A_FMSK, 32'h0000_0006);
        set_pads(32'h0000_000F);
        wait_clk(4);
        bus_read(A_STAT, rd);
        check(rd == 32'h0000_0005, "R8 rising capture", rd, 32'h0000_0005);
        check(irq == 1'b1, "R11 irq on pending", N'(irq), N'(1));
        set_pads(32'h0);
        wait_clk(4);
        bus_read(A_STAT, rd);
        check(rd == 32'h0000_0007, "R8 falling capture", rd, 32'h0000_0007);

        // R9: write-one-to-clear
        bus_write(A_ICLR, 32'h0000_0001);
        bus_read(A_STAT, rd);
        check(rd == 32'h0000_0006, "R9 partial clear", rd, 32'h0000_0006);
        bus_write(A_ICLR, 32'hFFFF_FFFF);
        bus_read(A_STAT, rd);
        check(rd == 32'h0, "R9 clear all", rd, 32'h0);
        check(irq == 1'b0, "R11 irq idle", N'(irq), '0);

        // R10: edge in the same cycle as its clear
        set_pads(32'h0000_0001);
        wait_clk(4);
        set_pads(32'h0000_0005);
        @(posedge clk);
        @(posedge clk);
        bus_write(A_ICLR, 32'h0000_0005);
        wait_clk(2);
        bus_read(A_STAT, rd);
        check(rd == 32'h0000_0004, "R10 edge beats clear", rd, 32'h0000_0004);
        bus_write(A_ICLR, 32'hFFFF_FFFF);
        wait_clk(2);
        check(irq == 1'b0, "R11 irq after clear", N'(irq), '0);

        wait_clk(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule